// File: doc/BRIEF.md
# Serial Port Interrupt Status and Mask Unit

This block gathers the seven interrupt sources of a synchronous serial port into one place. Level sources are the receive and transmit FIFO fill thresholds and the end-of-transmit condition. Event sources are receive overrun, receive idle timeout and the two DMA completion pulses. Every source lands in a raw status vector. A mask vector selects which raw bits reach the masked status view and the single interrupt line.

The FIFOs and the serial shift engine are outside the block and appear only as inputs: fill counts, a shift-busy flag, an activity strobe, a serial bit-period tick and event pulses. A small register port sets or clears mask bits, acknowledges the latched receive events, and returns either the raw or the masked status.

The receive idle timeout counts serial bit periods. The count runs while the receive FIFO holds data and no receive activity is seen. Once the count reaches the limit, the timeout bit latches.

Top module: `sport_irq_ctrl`

## Requirements
- R1: With `rd_masked` low, `rd_status` returns the raw vector with this bit order: 0 overrun, 1 receive timeout, 2 receive threshold, 3 transmit threshold, 4 receive DMA done, 5 transmit DMA done, 6 end of transmit.
- R2: Raw bit 2 is high one cycle after `rx_level >= FIFO_DEPTH/2`. Raw bit 3 is high one cycle after `tx_level <= FIFO_DEPTH/2`. Both follow their inputs and never hold a past value.
- R3: Raw bit 6 is high one cycle after `tx_level == 0` while `tx_shift_busy` is low, and low otherwise.
- R4: An `rx_overrun` pulse sets raw bit 0 on the next cycle. The bit stays set until it is acknowledged.
- R5: Raw bit 1 latches once `TMO_BITS` `bit_tick` cycles have passed while `rx_level` is non-zero and `rx_activity` is low. Any activity, or an empty receive FIFO, restarts the count.
- R6: A write to address 2 clears raw bits 0 and 1 wherever the write data bit is 1. The same write has no effect on bits 2 to 6 or on the mask.
- R7: When an overrun or timeout event occurs in the same cycle as an acknowledge of that bit, the bit ends up set.
- R8: `dma_rx_done` and `dma_tx_done` pulses latch raw bits 4 and 5. A mask-clear write (address 1) with the bit set clears that latched bit. A pulse in the same cycle wins over the clear.
- R9: A write to address 0 sets mask bits where the data is 1, and a write to address 1 clears them. Bits written as 0 keep their value. Writes to address 3 change nothing.
- R10: With `rd_masked` high, `rd_status` equals raw AND mask.
- R11: `irq` equals the OR of the masked status of the previous cycle.
- R12: While `rst_n` is low, raw status, mask and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | LVL_W | Receive FIFO fill count |
| tx_level | input | LVL_W | Transmit FIFO fill count |
| tx_shift_busy | input | 1 | Transmit shifter still holds bits |
| rx_activity | input | 1 | Receive FIFO push or pop this cycle |
| bit_tick | input | 1 | One pulse per serial bit period |
| rx_overrun | input | 1 | Receive overrun event pulse |
| dma_rx_done | input | 1 | Receive DMA completion pulse |
| dma_tx_done | input | 1 | Transmit DMA completion pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 mask set, 1 mask clear, 2 event acknowledge, 3 unused |
| reg_wdata | input | 7 | Register write data |
| rd_masked | input | 1 | Select masked (1) or raw (0) status view |
| rd_status | output | 7 | Selected status view |
| mask_out | output | 7 | Current mask vector |
| irq | output | 1 | Combined interrupt line |

## Verification
The bench builds the block with `FIFO_DEPTH` of 4 and `TMO_BITS` of 5. With these values, random fill counts often sit exactly on the half-depth threshold from both sides. They also make an empty transmit FIFO common. The short timeout lets random idle stretches fire the receive timeout many times, so acknowledge, re-arm and same-cycle collisions all occur against the model. The default 32-period limit uses the same counter path and only changes the saturation value.

// File: rtl/sport_irq_pkg.sv
package sport_irq_pkg;

    localparam int NSRC = 7;

    localparam int B_OVR  = 0;
    localparam int B_TMO  = 1;
    localparam int B_RXHI = 2;
    localparam int B_TXLO = 3;
    localparam int B_DRX  = 4;
    localparam int B_DTX  = 5;
    localparam int B_TEND = 6;

    localparam int NSTICKY = 4;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic [1:0] {
        REG_MASK_SET = 2'd0,
        REG_MASK_CLR = 2'd1,
        REG_EVT_ACK  = 2'd2,
        REG_NONE     = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/sport_irq_thresh.sv
module sport_irq_thresh #(
    parameter int FIFO_DEPTH = 8,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             tx_shift_busy,
    output logic             rx_hi,
    output logic             tx_lo,
    output logic             tx_end
);
    localparam int HALF = FIFO_DEPTH / 2;
    localparam logic [LVL_W-1:0] HALF_L = LVL_W'(HALF);

    always_comb begin
        rx_hi  = (rx_level >= HALF_L);
        tx_lo  = (tx_level <= HALF_L);
        tx_end = (tx_level == '0) && !tx_shift_busy;
    end
endmodule

// File: rtl/sport_irq_tmo.sv
module sport_irq_tmo #(
    parameter int TMO_BITS = 32,
    parameter int CW       = $clog2(TMO_BITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_nonempty,
    input  logic rx_activity,
    input  logic bit_tick,
    output logic fire
);
    localparam logic [CW-1:0] LIMIT   = CW'(TMO_BITS);
    localparam logic [CW-1:0] LIMIT_M = CW'(TMO_BITS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmo_st_t;

    tmo_st_t st_d, st_q;
    logic    qual;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        qual = rx_nonempty && !rx_activity;
        if (!qual) begin
            st_d.cnt = '0;
        end else if (bit_tick && (st_q.cnt != LIMIT)) begin
            fire     = (st_q.cnt == LIMIT_M);
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sport_irq_sticky.sv
module sport_irq_sticky #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } stk_st_t;

    stk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < W; i++) begin
            // a new event outranks a simultaneous acknowledge
            st_d.bits[i] = set_i[i] | (st_q.bits[i] & ~clr_i[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.bits;
endmodule

// File: rtl/sport_irq_ctrl.sv
module sport_irq_ctrl
    import sport_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int TMO_BITS   = 32,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             tx_shift_busy,
    input  logic             rx_activity,
    input  logic             bit_tick,
    input  logic             rx_overrun,
    input  logic             dma_rx_done,
    input  logic             dma_tx_done,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [NSRC-1:0]  reg_wdata,
    input  logic             rd_masked,
    output logic [NSRC-1:0]  rd_status,
    output logic [NSRC-1:0]  mask_out,
    output logic             irq
);
    typedef struct packed {
        src_vec_t mask;
        logic     rx_hi;
        logic     tx_lo;
        logic     tx_end;
        logic     irq;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic                rx_hi_c, tx_lo_c, tx_end_c;
    logic                tmo_fire;
    logic [NSTICKY-1:0]  stk_set, stk_clr, stk_q;
    src_vec_t            raw_q, masked_q;
    reg_sel_e            sel;
    logic                wr_set, wr_clr, wr_ack;

    sport_irq_thresh #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .LVL_W      (LVL_W)
    ) thresh_i (
        .rx_level      (rx_level),
        .tx_level      (tx_level),
        .tx_shift_busy (tx_shift_busy),
        .rx_hi         (rx_hi_c),
        .tx_lo         (tx_lo_c),
        .tx_end        (tx_end_c)
    );

    sport_irq_tmo #(
        .TMO_BITS (TMO_BITS)
    ) tmo_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_nonempty (rx_level != '0),
        .rx_activity (rx_activity),
        .bit_tick    (bit_tick),
        .fire        (tmo_fire)
    );

    always_comb begin
        sel    = reg_sel_e'(reg_addr);
        wr_set = reg_wr && (sel == REG_MASK_SET);
        wr_clr = reg_wr && (sel == REG_MASK_CLR);
        wr_ack = reg_wr && (sel == REG_EVT_ACK);

        // sticky slots: 0 overrun, 1 timeout, 2 rx dma, 3 tx dma
        stk_set = {dma_tx_done, dma_rx_done, tmo_fire, rx_overrun};
        stk_clr = {wr_clr & reg_wdata[B_DTX],
                   wr_clr & reg_wdata[B_DRX],
                   wr_ack & reg_wdata[B_TMO],
                   wr_ack & reg_wdata[B_OVR]};
    end

    sport_irq_sticky #(
        .W (NSTICKY)
    ) sticky_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (stk_set),
        .clr_i (stk_clr),
        .q_o   (stk_q)
    );

    always_comb begin
        raw_q         = '0;
        raw_q[B_OVR]  = stk_q[0];
        raw_q[B_TMO]  = stk_q[1];
        raw_q[B_RXHI] = st_q.rx_hi;
        raw_q[B_TXLO] = st_q.tx_lo;
        raw_q[B_DRX]  = stk_q[2];
        raw_q[B_DTX]  = stk_q[3];
        raw_q[B_TEND] = st_q.tx_end;
        masked_q      = raw_q & st_q.mask;
    end

    always_comb begin
        st_d        = st_q;
        st_d.rx_hi  = rx_hi_c;
        st_d.tx_lo  = tx_lo_c;
        st_d.tx_end = tx_end_c;
        if (wr_set) st_d.mask = st_d.mask | reg_wdata;
        if (wr_clr) st_d.mask = st_d.mask & ~reg_wdata;
        st_d.irq    = |masked_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_status = rd_masked ? masked_q : raw_q;
    assign mask_out  = st_q.mask;
    assign irq       = st_q.irq;
endmodule

// File: rtl/sport_irq_chk.sv
module sport_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic [6:0] reg_wdata,
    input logic       rx_overrun,
    input logic       dma_rx_done,
    input logic [6:0] raw,
    input logic [6:0] mask,
    input logic       irq
);
    // R4
    ovr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> raw[0]);

    // R6
    ovr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2 && reg_wdata[0] && !rx_overrun) |=> !raw[0]);

    // R8
    dma_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rx_done |=> raw[4]);

    // R9
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0) |=>
            (((mask & ~$past(reg_wdata)) == ($past(mask) & ~$past(reg_wdata))) &&
             ((mask & $past(reg_wdata)) == $past(reg_wdata))));

    // R9
    mask_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr || reg_addr[1]) |=> $stable(mask));

    // R11
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(raw & mask)) |=> irq);

    // R11
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(raw & mask)) |=> !irq);
endmodule

bind sport_irq_ctrl sport_irq_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .rx_overrun  (rx_overrun),
    .dma_rx_done (dma_rx_done),
    .raw         (raw_q),
    .mask        (mask_out),
    .irq         (irq)
);

// File: tb/sport_irq_ctrl_tb.sv
module sport_irq_ctrl_tb_top;
    localparam int DEPTH = 4;
    localparam int TMO   = 5;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LVL_W-1:0] rx_level = '0;
    logic [LVL_W-1:0] tx_level = '0;
    logic             tx_shift_busy = 1'b0;
    logic             rx_activity = 1'b0;
    logic             bit_tick = 1'b0;
    logic             rx_overrun = 1'b0;
    logic             dma_rx_done = 1'b0;
    logic             dma_tx_done = 1'b0;
    logic             reg_wr = 1'b0;
    logic [1:0]       reg_addr = '0;
    logic [6:0]       reg_wdata = '0;
    logic             rd_masked = 1'b0;
    logic [6:0]       rd_status;
    logic [6:0]       mask_out;
    logic             irq;

    int total = 0;
    int bad   = 0;
    int ncyc  = 0;
    bit done  = 1'b0;

    logic [6:0] m_raw = '0;
    logic [6:0] m_mask = '0;
    logic       m_irq = 1'b0;
    int         m_cnt = 0;

    always #4 clk = ~clk;
    always @(posedge clk) ncyc++;

    sport_irq_ctrl #(
        .FIFO_DEPTH (DEPTH),
        .TMO_BITS   (TMO)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_level      (rx_level),
        .tx_level      (tx_level),
        .tx_shift_busy (tx_shift_busy),
        .rx_activity   (rx_activity),
        .bit_tick      (bit_tick),
        .rx_overrun    (rx_overrun),
        .dma_rx_done   (dma_rx_done),
        .dma_tx_done   (dma_tx_done),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .rd_masked     (rd_masked),
        .rd_status     (rd_status),
        .mask_out      (mask_out),
        .irq           (irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, ncyc);
        end
    endtask

    function automatic logic exp_rx_hi(input int lvl);
        return lvl >= DEPTH / 2;
    endfunction

    function automatic logic exp_tx_lo(input int lvl);
        return lvl <= DEPTH / 2;
    endfunction

    task automatic get_raw(output logic [6:0] v);
        rd_masked = 1'b0;
        #1;
        v = rd_status;
    endtask

    // one clock step with model update and compare of every visible output
    task automatic cyc();
        logic [6:0] nraw, nmask;
        logic       nirq, qual, fire, ev, mc, ms;
        int         ncnt;
        qual = (rx_level != 0) && !rx_activity;
        fire = 1'b0;
        ncnt = m_cnt;
        if (!qual) ncnt = 0;
        else if (bit_tick && m_cnt != TMO) begin
            fire = (m_cnt == TMO - 1);
            ncnt = m_cnt + 1;
        end
        ms = reg_wr && reg_addr == 2'd0;
        mc = reg_wr && reg_addr == 2'd1;
        ev = reg_wr && reg_addr == 2'd2;
        nraw[0] = rx_overrun  | (m_raw[0] & ~(ev & reg_wdata[0]));
        nraw[1] = fire        | (m_raw[1] & ~(ev & reg_wdata[1]));
        nraw[2] = exp_rx_hi(int'(rx_level));
        nraw[3] = exp_tx_lo(int'(tx_level));
        nraw[4] = dma_rx_done | (m_raw[4] & ~(mc & reg_wdata[4]));
        nraw[5] = dma_tx_done | (m_raw[5] & ~(mc & reg_wdata[5]));
        nraw[6] = (tx_level == 0) && !tx_shift_busy;
        nmask = m_mask;
        if (ms) nmask = nmask | reg_wdata;
        if (mc) nmask = nmask & ~reg_wdata;
        nirq = |(m_raw & m_mask);
        @(posedge clk);
        @(negedge clk);
        m_raw = nraw; m_mask = nmask; m_irq = nirq; m_cnt = ncnt;
        rx_overrun = 1'b0; dma_rx_done = 1'b0; dma_tx_done = 1'b0;
        reg_wr = 1'b0; rx_activity = 1'b0;
        rd_masked = 1'b0;
        #1;
        chk(rd_status == m_raw, "R1 raw view", int'(rd_status), int'(m_raw));
        rd_masked = 1'b1;
        #1;
        chk(rd_status == (m_raw & m_mask), "R10 masked view", int'(rd_status), int'(m_raw & m_mask));
        chk(mask_out == m_mask, "R9 mask", int'(mask_out), int'(m_mask));
        chk(irq == m_irq, "R11 irq", int'(irq), int'(m_irq));
        rd_masked = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [6:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    endtask

    initial begin : watchdog
        wait (ncyc >= 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", ncyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [6:0] v;
        void'($urandom(32'd20240611));

        // R12: reset holds everything at zero despite busy inputs
        rx_level = LVL_W'(DEPTH); rx_overrun = 1'b1; dma_rx_done = 1'b1;
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 7'h7F;
        repeat (3) @(negedge clk);
        rd_masked = 1'b0; #1;
        chk(rd_status == 7'h00, "R12 raw in reset", int'(rd_status), 0);
        chk(mask_out == 7'h00, "R12 mask in reset", int'(mask_out), 0);
        chk(irq == 1'b0, "R12 irq in reset", int'(irq), 0);
        rx_overrun = 1'b0; dma_rx_done = 1'b0; reg_wr = 1'b0;
        rx_level = '0; tx_level = LVL_W'(DEPTH); tx_shift_busy = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        cyc();

        // R9: set, clear, unused address
        wr(2'd0, 7'h7F); cyc();
        wr(2'd1, 7'h55); cyc();
        chk(mask_out == 7'h2A, "R9 per-bit clear", int'(mask_out), 'h2A);
        wr(2'd3, 7'h7F); cyc();
        chk(mask_out == 7'h2A, "R9 address 3 ignored", int'(mask_out), 'h2A);
        wr(2'd1, 7'h7F); cyc();

        // R2: thresholds on both sides of half depth
        rx_level = LVL_W'(DEPTH / 2); cyc(); cyc(); get_raw(v);
        chk(v[2] == 1'b1, "R2 rx at half", int'(v[2]), 1);
        rx_level = LVL_W'(DEPTH / 2 - 1); cyc(); get_raw(v);
        chk(v[2] == 1'b0, "R2 rx below half", int'(v[2]), 0);
        tx_level = LVL_W'(DEPTH / 2); cyc(); get_raw(v);
        chk(v[3] == 1'b1, "R2 tx at half", int'(v[3]), 1);
        tx_level = LVL_W'(DEPTH / 2 + 1); cyc(); get_raw(v);
        chk(v[3] == 1'b0, "R2 tx above half", int'(v[3]), 0);

        // R3: end of transmit needs empty FIFO and idle shifter
        tx_level = '0; tx_shift_busy = 1'b1; cyc(); get_raw(v);
        chk(v[6] == 1'b0, "R3 shifter busy", int'(v[6]), 0);
        tx_shift_busy = 1'b0; cyc(); get_raw(v);
        chk(v[6] == 1'b1, "R3 transmit done", int'(v[6]), 1);

        // R4 / R6 / R11: overrun latch, irq one cycle after raw
        rx_level = '0;
        wr(2'd0, 7'h01); cyc();
        rx_overrun = 1'b1; cyc(); get_raw(v);
        chk(v[0] == 1'b1, "R4 overrun latched", int'(v[0]), 1);
        chk(irq == 1'b0, "R11 irq not yet", int'(irq), 0);
        cyc(); cyc(); get_raw(v);
        chk(v[0] == 1'b1, "R4 overrun sticky", int'(v[0]), 1);
        chk(irq == 1'b1, "R11 irq raised", int'(irq), 1);
        wr(2'd2, 7'h7C); cyc(); get_raw(v);
        chk(v[0] == 1'b1 && v[6] == 1'b1, "R6 other bits ignored", int'(v), 'h49);
        chk(mask_out == 7'h01, "R6 mask untouched", int'(mask_out), 1);
        wr(2'd2, 7'h01); cyc(); get_raw(v);
        chk(v[0] == 1'b0, "R6 overrun acknowledged", int'(v[0]), 0);

        // R7: event and acknowledge together
        rx_overrun = 1'b1; wr(2'd2, 7'h01); cyc(); get_raw(v);
        chk(v[0] == 1'b1, "R7 set wins", int'(v[0]), 1);
        wr(2'd2, 7'h03); cyc();

        // R5: timeout fires after exactly TMO idle ticks
        rx_level = 'd1; rx_activity = 1'b1; bit_tick = 1'b1; cyc();
        repeat (TMO - 1) cyc();
        get_raw(v);
        chk(v[1] == 1'b0, "R5 not before limit", int'(v[1]), 0);
        cyc(); get_raw(v);
        chk(v[1] == 1'b1, "R5 fired at limit", int'(v[1]), 1);
        wr(2'd2, 7'h02); rx_activity = 1'b1; cyc();
        repeat (TMO - 1) cyc();
        rx_activity = 1'b1; cyc();
        repeat (TMO - 1) cyc();
        get_raw(v);
        chk(v[1] == 1'b0, "R5 activity restarts count", int'(v[1]), 0);
        bit_tick = 1'b0; rx_level = '0; cyc();

        // R8: DMA done latch, clear via mask clear, set wins
        dma_rx_done = 1'b1; dma_tx_done = 1'b1; cyc(); get_raw(v);
        chk(v[5:4] == 2'b11, "R8 dma latched", int'(v[5:4]), 3);
        wr(2'd1, 7'h10); cyc(); get_raw(v);
        chk(v[5:4] == 2'b10, "R8 rx dma cleared", int'(v[5:4]), 2);
        dma_tx_done = 1'b1; wr(2'd1, 7'h20); cyc(); get_raw(v);
        chk(v[5] == 1'b1, "R8 pulse beats clear", int'(v[5]), 1);
        wr(2'd1, 7'h20); cyc();

        // mixed random phase against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 4) == 0) rx_level = LVL_W'($urandom_range(0, DEPTH));
            if ($urandom_range(0, 3) == 0) tx_level = LVL_W'($urandom_range(0, DEPTH));
            tx_shift_busy = ($urandom_range(0, 2) == 0);
            rx_activity   = ($urandom_range(0, 9) == 0);
            bit_tick      = ($urandom_range(0, 9) < 6);
            rx_overrun    = ($urandom_range(0, 19) == 0);
            dma_rx_done   = ($urandom_range(0, 19) == 0);
            dma_tx_done   = ($urandom_range(0, 19) == 0);
            if ($urandom_range(0, 3) == 0)
                wr(2'($urandom_range(0, 3)), 7'($urandom_range(0, 127)));
            cyc();
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule